// File: doc/BRIEF.md
# Four-Byte Serial Programming Target Front End

This block sits on the target side of an in-system programming port. An external programmer drives a serial clock, a data line into the target and an active-high line that holds the target in programming mode; the block returns data on its own serial output. Both incoming lines are brought into the fast system clock through synchronisers, and the block finds the serial clock edges there. Bits arrive most significant first. Every instruction is exactly 32 bits long: an opcode byte, two address bytes and a data byte.

Two things are sent back on the output line. During the third byte, the block returns the second byte of the current instruction. A programmer uses this echo to confirm that it is still aligned with the target. During the fourth byte, the block returns a byte supplied by the memory side. When 24 bits have arrived, the block issues a one-cycle read request that carries the opcode and the address. The memory side answers on `rd_data_i`.

When all 32 bits are in, the block offers the whole instruction to the memory side over a valid/ready handshake. A frame always runs to its 32nd bit, whatever was echoed. If the link has lost alignment, a pulse on the programming-reset line clears the position in the frame.

Top module: `isp_serial_slave`

## Requirements
- R1: The data input is sampled on rising serial-clock edges, most significant bit first. In a completed instruction, `cmd_op_o` holds the first byte, `cmd_addr_o` holds the second byte in bits 15:8 and the third byte in bits 7:0, and `cmd_data_o` holds the fourth byte.
- R2: `miso_o` changes only in the cycle after a falling serial-clock edge is detected.
- R3: `cmd_valid_o` rises after exactly 32 rising edges counted from reset or from the last frame boundary, and at no other time.
- R4: While the third byte is clocked in, `miso_o` carries the second byte of the same instruction, MSB first. The byte 0x53 is one such value. A frame whose echo does not match still completes after its 32 bits.
- R5: `rd_req_o` is a one-cycle pulse after the 24th bit, with `rd_op_o` set to the first byte and `rd_addr_o` set to bytes two and three. The value on `rd_data_i` at the next falling edge is shifted out on `miso_o` during the fourth byte, MSB first.
- R6: `miso_o` is 0 throughout the first and second bytes of every instruction.
- R7: A high pulse on `prog_rst_i` returns the bit position to the start of a frame. The next 32 bits then form one correctly aligned instruction, even if a stray bit arrived before the pulse.
- R8: `cmd_valid_o` stays high, with its fields stable, until a cycle in which `cmd_ready_i` is high; it then falls. A frame that completes while a command is still pending is dropped.
- R9: After `rst_ni` is released, `miso_o`, `cmd_valid_o` and `rd_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the programmer |
| mosi_i | input | 1 | Serial data from the programmer |
| prog_rst_i | input | 1 | Active-high programming reset; a pulse realigns the framer |
| miso_o | output | 1 | Serial data to the programmer |
| rd_req_o | output | 1 | One-cycle read request after the third byte |
| rd_op_o | output | 8 | Opcode for the read request |
| rd_addr_o | output | 16 | Address for the read request |
| rd_data_i | input | 8 | Byte returned by the memory side for the fourth slot |
| cmd_valid_o | output | 1 | A complete instruction is available |
| cmd_ready_i | input | 1 | The memory side accepts the instruction |
| cmd_op_o | output | 8 | Opcode byte of the instruction |
| cmd_addr_o | output | 16 | Address bytes of the instruction |
| cmd_data_o | output | 8 | Data byte of the instruction |

## Verification
If the bit position is off by even one bit, the very next instruction shows it on the ports. The echo during the third byte is shifted, and the command fields are rotated, within 32 serial clocks. A wrong byte-slot selection in the output shifter shows up within 8 serial clocks of the slot in question, as a non-zero lead byte, a wrong echo or wrong read data. A handshake fault appears on `cmd_valid_o` within one system cycle of the frame end or of the accepting cycle. The bench also feeds the block a stray bit and checks the misaligned fields that result. It then realigns with a programming-reset pulse.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 4;
  localparam int ADDR_BYTES  = 2;
  localparam int FRAME_BITS  = BYTE_W * FRAME_BYTES;
  localparam int POS_W       = $clog2(FRAME_BITS);
  localparam int LANE_W      = $clog2(BYTE_W);
  localparam int ADDR_W      = BYTE_W * ADDR_BYTES;
  // byte slots on the return line
  localparam int ECHO_SLOT   = 2;
  localparam int READ_SLOT   = 3;

  typedef struct packed {
    logic [BYTE_W-1:0] op;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } isp_cmd_t;
endpackage

// File: rtl/isp_sync.sv
module isp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/isp_rx_framer.sv
module isp_rx_framer
  import isp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              mosi_i,
  output logic [POS_W-1:0]  pos_o,
  output logic [BYTE_W-1:0] echo_o,
  output logic              rd_req_o,
  output logic [BYTE_W-1:0] rd_op_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              done_o,
  output isp_cmd_t          word_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] ECHO_POS = POS_W'(2 * BYTE_W - 1);
  localparam logic [POS_W-1:0] REQ_POS  = POS_W'(3 * BYTE_W - 1);

  logic [FRAME_BITS-2:0] rx_q;
  logic [FRAME_BITS-1:0] nxt;

  assign nxt = {rx_q, mosi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q      <= '0;
      pos_o     <= '0;
      echo_o    <= '0;
      rd_req_o  <= 1'b0;
      rd_op_o   <= '0;
      rd_addr_o <= '0;
      done_o    <= 1'b0;
      word_o    <= '0;
    end else if (clr_i) begin
      rx_q     <= '0;
      pos_o    <= '0;
      echo_o   <= '0;
      rd_req_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      rd_req_o <= 1'b0;
      done_o   <= 1'b0;
      if (rise_i) begin
        rx_q  <= nxt[FRAME_BITS-2:0];
        pos_o <= (pos_o == LAST_POS) ? '0 : pos_o + 1'b1;
        if (pos_o == ECHO_POS) echo_o <= nxt[BYTE_W-1:0];
        if (pos_o == REQ_POS) begin
          rd_req_o  <= 1'b1;
          rd_op_o   <= nxt[3*BYTE_W-1 -: BYTE_W];
          rd_addr_o <= nxt[ADDR_W-1:0];
        end
        if (pos_o == LAST_POS) begin
          done_o <= 1'b1;
          word_o <= isp_cmd_t'(nxt);
        end
      end
    end
  end

  // R7
  clr_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> pos_o == '0);

  // R5
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
endmodule

// File: rtl/isp_tx_shifter.sv
module isp_tx_shifter
  import isp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              fall_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [BYTE_W-1:0] echo_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              miso_o
);
  localparam int SLOT_W = POS_W - LANE_W;

  logic [BYTE_W-1:0] tx_q;
  logic [BYTE_W-1:0] load_byte;
  logic [SLOT_W-1:0] slot;
  logic              at_boundary;

  assign slot        = pos_i[POS_W-1:LANE_W];
  assign at_boundary = (pos_i[LANE_W-1:0] == '0);

  always_comb begin
    load_byte = '0;
    if (slot == SLOT_W'(ECHO_SLOT)) load_byte = echo_i;
    if (slot == SLOT_W'(READ_SLOT)) load_byte = rd_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tx_q <= '0;
    else if (clr_i)  tx_q <= '0;
    else if (fall_i) tx_q <= at_boundary ? load_byte : {tx_q[BYTE_W-2:0], 1'b0};
  end

  assign miso_o = tx_q[BYTE_W-1];

  // R6
  zero_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_i && !clr_i && pos_i < POS_W'(ECHO_SLOT * BYTE_W)) |=> !miso_o);
endmodule

// File: rtl/isp_serial_slave.sv
module isp_serial_slave
  import isp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sck_i,
  input  logic        mosi_i,
  input  logic        prog_rst_i,
  output logic        miso_o,
  output logic        rd_req_o,
  output logic [7:0]  rd_op_o,
  output logic [15:0] rd_addr_o,
  input  logic [7:0]  rd_data_i,
  output logic        cmd_valid_o,
  input  logic        cmd_ready_i,
  output logic [7:0]  cmd_op_o,
  output logic [15:0] cmd_addr_o,
  output logic [7:0]  cmd_data_o
);
  logic [2:0]         sync_q;
  logic               sck_s, mosi_s, prst_s, sck_d;
  logic               rise, fall;
  logic [POS_W-1:0]   pos;
  logic [BYTE_W-1:0]  echo;
  logic               done;
  isp_cmd_t           word, cmd_q;

  isp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({prog_rst_i, mosi_i, sck_i}),
    .q_o   (sync_q)
  );

  assign {prst_s, mosi_s, sck_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d <= 1'b0;
    else         sck_d <= sck_s;
  end

  assign rise = sck_s & ~sck_d;
  assign fall = ~sck_s & sck_d;

  isp_rx_framer u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (prst_s),
    .rise_i   (rise),
    .mosi_i   (mosi_s),
    .pos_o    (pos),
    .echo_o   (echo),
    .rd_req_o (rd_req_o),
    .rd_op_o  (rd_op_o),
    .rd_addr_o(rd_addr_o),
    .done_o   (done),
    .word_o   (word)
  );

  isp_tx_shifter u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (prst_s),
    .fall_i   (fall),
    .pos_i    (pos),
    .echo_i   (echo),
    .rd_data_i(rd_data_i),
    .miso_o   (miso_o)
  );

  // a frame completing while one is pending is dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      cmd_q       <= '0;
    end else if (done && !cmd_valid_o) begin
      cmd_valid_o <= 1'b1;
      cmd_q       <= word;
    end else if (cmd_valid_o && cmd_ready_i) begin
      cmd_valid_o <= 1'b0;
    end
  end

  assign cmd_op_o   = cmd_q.op;
  assign cmd_addr_o = cmd_q.addr;
  assign cmd_data_o = cmd_q.data;

  // R2
  miso_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(miso_o) |-> $past(fall) || $past(prst_s));

  // R8
  valid_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_addr_o) && $stable(cmd_data_o)));

  // R3
  frame_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_valid_o) |-> pos == '0);
endmodule

// File: tb/isp_serial_slave_tb_top.sv
module isp_serial_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic        clk = 1'b0;
  logic        rst_n, sck, mosi, prog_rst, cmd_ready;
  logic        miso, rd_req, cmd_valid;
  logic [7:0]  rd_op, rd_data, cmd_op, cmd_data;
  logic [15:0] rd_addr, cmd_addr;

  int total = 0;
  int bad   = 0;
  int req_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  assign rd_data = mem_f(rd_addr);

  always @(posedge clk) if (rd_req === 1'b1) req_cnt++;

  isp_serial_slave dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sck_i      (sck),
    .mosi_i     (mosi),
    .prog_rst_i (prog_rst),
    .miso_o     (miso),
    .rd_req_o   (rd_req),
    .rd_op_o    (rd_op),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data),
    .cmd_valid_o(cmd_valid),
    .cmd_ready_i(cmd_ready),
    .cmd_op_o   (cmd_op),
    .cmd_addr_o (cmd_addr),
    .cmd_data_o (cmd_data)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic got);
    mosi = b;
    wait_clk(HALF);
    got = miso;
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic send_frame(input logic [31:0] w, input bit check, input string rq);
    logic [7:0] exp_q[$];
    logic [31:0] got;
    logic b;
    int req0;
    req0 = req_cnt;
    exp_q.push_back(8'h00);
    exp_q.push_back(8'h00);
    exp_q.push_back(w[23:16]);
    exp_q.push_back(mem_f(w[23:8]));
    got = '0;
    for (int i = 31; i >= 0; i--) begin
      send_bit(w[i], b);
      got[i] = b;
    end
    wait_clk(HALF);
    if (check) begin
      chk({"R6 lead byte 1 ", rq}, {24'd0, got[31:24]}, {24'd0, exp_q.pop_front()});
      chk({"R6 lead byte 2 ", rq}, {24'd0, got[23:16]}, {24'd0, exp_q.pop_front()});
      chk({"R4 echo ", rq},        {24'd0, got[15:8]},  {24'd0, exp_q.pop_front()});
      chk({"R5 read byte ", rq},   {24'd0, got[7:0]},   {24'd0, exp_q.pop_front()});
      chk({"R5 one request ", rq}, req_cnt - req0, 1);
      chk({"R5 request op ", rq},  {24'd0, rd_op}, {24'd0, w[31:24]});
      chk({"R5 request addr ", rq}, {16'd0, rd_addr}, {16'd0, w[23:8]});
      chk({"R3 valid after 32 bits ", rq}, {31'd0, cmd_valid}, 1);
      chk({"R1 fields ", rq}, {cmd_op, cmd_addr, cmd_data}, w);
    end
  endtask

  task automatic consume(input string rq);
    wait_clk(10);
    chk({"R8 valid held ", rq}, {31'd0, cmd_valid}, 1);
    cmd_ready = 1'b1;
    wait_clk(1);
    cmd_ready = 1'b0;
    chk({"R8 valid cleared ", rq}, {31'd0, cmd_valid}, 0);
  endtask

  initial begin
    logic b;
    rst_n = 1'b0; sck = 1'b0; mosi = 1'b0; prog_rst = 1'b0; cmd_ready = 1'b0;
    wait_clk(5);
    chk("R9 miso reset", {31'd0, miso}, 0);
    chk("R9 valid reset", {31'd0, cmd_valid}, 0);
    chk("R9 rd_req reset", {31'd0, rd_req}, 0);
    rst_n = 1'b1;
    wait_clk(6);

    send_frame(32'hAC53_0000, 1'b1, "enable");
    consume("enable");

    send_frame(32'h2001_2A00, 1'b1, "read");
    consume("read");

    // R4: mismatching echo still yields a full frame
    send_frame(32'hAC77_1234, 1'b1, "bad echo");
    consume("bad echo");

    // R7: stray bit misaligns the next instruction
    send_bit(1'b0, b);
    send_frame(32'hAC53_0000, 1'b0, "stray");
    chk("R7 misaligned valid", {31'd0, cmd_valid}, 1);
    chk("R7 misaligned op", {24'd0, cmd_op}, 32'h56);
    chk("R7 misaligned addr", {16'd0, cmd_addr}, 32'h2980);
    consume("R7 stray");

    prog_rst = 1'b1;
    wait_clk(6);
    prog_rst = 1'b0;
    wait_clk(6);
    chk("R7 miso after pulse", {31'd0, miso}, 0);
    send_frame(32'hAC53_0000, 1'b1, "R7 realigned");
    consume("R7 realigned");

    send_frame(32'h58FF_00C3, 1'b1, "R1 pattern");
    consume("R1 pattern");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog R3 actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule